// File: doc/BRIEF.md
# Edge/Level Interrupt Collector

This block gathers 32 interrupt request lines per bank, with one or two banks, into a single interrupt request for a processor. Each line is fixed at build time as edge-type or level-type by a constant mask for its bank. On an edge-type line, a rising edge sets a sticky bit that software later acknowledges. On a level-type line, the live input drives the request for as long as it is high. Software reaches four word registers per bank over a simple register bus: a latched-event word, a mask word, a write-ones acknowledge word, and a raw-input word.

The request output goes high when any enabled event is pending in any bank. The raw-input word ignores the mask. Software can read it when it unmasks a level line to find a request that arrived while the line was masked. To cascade two blocks, connect the request output of one instance to an input line of another. Software must keep that line enabled and must never report it as a device event.

With two banks, the bank for lines 32–63 is mapped at byte offset 0x10 and the bank for lines 0–31 at 0x20. Within a bank the words sit at +0x0 (latched events), +0x4 (mask), +0x8 (acknowledge) and +0xC (raw input).

Top module: `legacy_irq_ctrl`

## Requirements
- R1: After reset, every register in both banks reads zero and `irqOut` is low.
- R2: A rising edge on an edge-type line sets its bit in the latched-event word. The bit stays set after the input falls again. An edge takes three clock edges to reach the word: two synchroniser flops and the detector.
- R3: Writing the acknowledge word (+0x8) clears exactly the latched bits written as one and leaves all other bits alone. Writing 0xFFFFFFFF clears every latched bit of that bank.
- R4: If a rising edge and an acknowledge of the same bit take effect on the same clock edge, the bit stays set.
- R5: Lines inside the level mask (the lower bank defaults to bits 20–28, 0x1FF00000; the upper bank defaults to no bits) never set latched bits. Their request follows the synchronised input ANDed with the mask word.
- R6: The raw-input word (+0xC) returns the synchronised level of every line, whatever the mask word holds.
- R7: A pending event raises `irqOut` only while its bit in the mask word (+0x4) is one. Writing 0 to the mask word blocks all requests. A latched edge event that was masked raises `irqOut` once it is unmasked.
- R8: `irqOut` is registered. It changes on the clock edge after the cycle in which the pending condition changes.
- R9: The acknowledge word always reads zero. Writes to the latched-event word and to the raw-input word have no effect.
- R10: The upper bank at 0x10 holds lines 32–63 in its own registers and has no level lines. Its enabled events also drive `irqOut`.
- R11: Read data appears on `busRdata` one clock after the read is sampled. An access whose low two address bits are not zero, or which maps to no bank, does not hit any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irqLines | input | NumBanks*32 | Interrupt request inputs; line n is bit n |
| irqOut | output | 1 | Combined interrupt request, registered |

## Verification
The bench sends single pulses on edge lines, widely spaced bits (0, 5, 31) together, held levels on mask lines, and pulses on upper-bank lines, including bit 28 of the upper bank, which would be a level line in the lower bank. Pulses that end before the read show the difference between sticky latching and level following. Acknowledges with unrelated bits, and with all ones, show whether a clear is selective. An edge is placed so that it lands on the same clock edge as its acknowledge, which shows which side wins the collision. Writes to the read-only words are made while those words hold known values, so any change made by the write is visible.

// File: rtl/legacy_irq_pkg.sv
package legacy_irq_pkg;
  localparam int unsigned BankW = 32;
  localparam int unsigned MaxBanks = 2;
  localparam int unsigned AddrW = 6;

  typedef enum logic [1:0] {
    RegState  = 2'd0,
    RegEnable = 2'd1,
    RegClear  = 2'd2,
    RegLevel  = 2'd3
  } reg_e;

  typedef struct packed {
    logic [MaxBanks-1:0] bankHit;
    logic                wr;
    logic                rd;
    reg_e                regSel;
  } strobe_t;
endpackage

// File: rtl/legacy_irq_decode.sv
module legacy_irq_decode
  import legacy_irq_pkg::*;
#(
  parameter int unsigned NumBanks = 2
) (
  input  logic             busSel,
  input  logic             busWr,
  input  logic [AddrW-1:0] busAddr,
  output strobe_t          strobes
);
  logic aligned;
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobes = '0;
    strobes.wr = busSel & busWr;
    strobes.rd = busSel & ~busWr;
    strobes.regSel = reg_e'(busAddr[3:2]);
    if (busSel && aligned) begin
      if (busAddr[5:4] == 2'b10) strobes.bankHit[0] = 1'b1;
      else if (busAddr[5:4] == 2'b01 && NumBanks > 1) strobes.bankHit[1] = 1'b1;
    end
  end
endmodule

// File: rtl/legacy_irq_banks.sv
module legacy_irq_banks
  import legacy_irq_pkg::*;
#(
  parameter int unsigned       NumBanks    = 2,
  parameter logic [BankW-1:0]  LevelMaskLo = 32'h1ff0_0000,
  parameter logic [BankW-1:0]  LevelMaskHi = 32'h0000_0000,
  localparam int unsigned      Lines       = NumBanks * BankW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Lines-1:0] irqLines,
  input  strobe_t          strobes,
  input  logic [BankW-1:0] wdata,
  output logic [BankW-1:0] rdData,
  output logic             irqOut,
  output logic [Lines-1:0] stateAll,
  output logic [Lines-1:0] enAll
);
  logic [BankW-1:0] bankRd [NumBanks];
  logic [NumBanks-1:0] pend;
  logic [BankW-1:0] rdNext;

  for (genvar b = 0; b < NumBanks; b++) begin : g_bank
    localparam logic [BankW-1:0] LvlMask = (b == 0) ? LevelMaskLo : LevelMaskHi;
    logic [BankW-1:0] syncA, syncB, prevB, stateQ, enQ, rise, clrBits;
    logic hit;

    assign hit = strobes.bankHit[b];
    assign rise = syncB & ~prevB;
    assign clrBits = (hit && strobes.wr && strobes.regSel == RegClear) ? wdata : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA  <= '0;
        syncB  <= '0;
        prevB  <= '0;
        stateQ <= '0;
        enQ    <= '0;
      end else begin
        syncA  <= irqLines[b*BankW +: BankW];
        syncB  <= syncA;
        prevB  <= syncB;
        // a new edge overrides a same-cycle acknowledge
        stateQ <= (stateQ & ~clrBits) | (rise & ~LvlMask);
        if (hit && strobes.wr && strobes.regSel == RegEnable) enQ <= wdata;
      end
    end

    assign pend[b] = |((stateQ & enQ & ~LvlMask) | (syncB & enQ & LvlMask));

    assign bankRd[b] = (strobes.regSel == RegState)  ? stateQ :
                       (strobes.regSel == RegEnable) ? enQ :
                       (strobes.regSel == RegLevel)  ? syncB : '0;

    assign stateAll[b*BankW +: BankW] = stateQ;
    assign enAll[b*BankW +: BankW]    = enQ;
  end

  always_comb begin
    rdNext = '0;
    for (int b = 0; b < NumBanks; b++)
      if (strobes.rd && strobes.bankHit[b]) rdNext = bankRd[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      irqOut <= 1'b0;
    end else begin
      rdData <= rdNext;
      irqOut <= |pend;
    end
  end
endmodule

// File: rtl/legacy_irq_ctrl.sv
module legacy_irq_ctrl
  import legacy_irq_pkg::*;
#(
  parameter int unsigned      NumBanks    = 2,
  parameter logic [BankW-1:0] LevelMaskLo = 32'h1ff0_0000,
  parameter logic [BankW-1:0] LevelMaskHi = 32'h0000_0000,
  localparam int unsigned     Lines       = NumBanks * BankW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [AddrW-1:0] busAddr,
  input  logic [BankW-1:0] busWdata,
  output logic [BankW-1:0] busRdata,
  input  logic [Lines-1:0] irqLines,
  output logic             irqOut
);
  strobe_t strobes;
  logic [Lines-1:0] stateAll;
  logic [Lines-1:0] enAll;

  legacy_irq_decode #(.NumBanks(NumBanks)) u_decode (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobes(strobes)
  );

  legacy_irq_banks #(
    .NumBanks   (NumBanks),
    .LevelMaskLo(LevelMaskLo),
    .LevelMaskHi(LevelMaskHi)
  ) u_banks (
    .clk     (clk),
    .rstN    (rstN),
    .irqLines(irqLines),
    .strobes (strobes),
    .wdata   (busWdata),
    .rdData  (busRdata),
    .irqOut  (irqOut),
    .stateAll(stateAll),
    .enAll   (enAll)
  );
endmodule

// File: rtl/legacy_irq_chk.sv
module legacy_irq_chk
  import legacy_irq_pkg::*;
#(
  parameter int unsigned      NumBanks    = 2,
  parameter logic [BankW-1:0] LevelMaskLo = 32'h1ff0_0000,
  parameter logic [BankW-1:0] LevelMaskHi = 32'h0000_0000,
  localparam int unsigned     Lines       = NumBanks * BankW
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic [AddrW-1:0] busAddr,
  input logic [BankW-1:0] busRdata,
  input logic             irqOut,
  input logic [Lines-1:0] stateAll,
  input logic [Lines-1:0] enAll
);
  localparam logic [Lines-1:0] LvlAll = Lines'({LevelMaskHi, LevelMaskLo});

  logic clrWr, clrRd;
  assign clrWr = busSel & busWr & (busAddr[3:0] == 4'h8);
  assign clrRd = busSel & ~busWr & (busAddr[3:0] == 4'h8);

  // R2
  sticky_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((stateAll & $past(stateAll)) == $past(stateAll)));

  // R5
  level_no_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateAll & LvlAll) == '0);

  // R7
  mask_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enAll == '0) |=> !irqOut);

  // R8
  edge_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateAll & enAll & ~LvlAll) != '0) |=> irqOut);

  // R9
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrRd |=> (busRdata == '0));
endmodule

bind legacy_irq_ctrl legacy_irq_chk #(
  .NumBanks   (NumBanks),
  .LevelMaskLo(LevelMaskLo),
  .LevelMaskHi(LevelMaskHi)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .stateAll(stateAll),
  .enAll   (enAll)
);

// File: tb/legacy_irq_ctrl_test.sv
`timescale 1ns/1ps
module legacy_irq_ctrl_test;
  localparam int unsigned Lines = 64;
  localparam logic [5:0] HiState = 6'h10, HiEn = 6'h14, HiClr = 6'h18, HiLvl = 6'h1C;
  localparam logic [5:0] LoState = 6'h20, LoEn = 6'h24, LoClr = 6'h28, LoLvl = 6'h2C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0;
  logic busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [Lines-1:0] irqLines = '0;
  logic irqOut;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  logic rdIss = 1'b0;

  always #2.5 clk = ~clk;

  legacy_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqLines(irqLines), .irqOut(irqOut)
  );

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busSel = 1'b0; busWr = 1'b0;
  endtask

  // driver: issue a read and queue the value the requirements predict
  task automatic busRead(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(posedge clk);
    #1 busSel = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkIrq(input logic e, input string tag);
    total++;
    if (irqOut !== e) begin
      bad++;
      $display("FAIL %s: irqOut=%b expected %b", tag, irqOut, e);
    end
  endtask

  always @(posedge clk) rdIss <= busSel & ~busWr;

  // monitor: read data is due one clock after the sampled read (R11)
  always @(negedge clk) begin
    if (rdIss) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (busRdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h expected %h", t, busRdata, e);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    checkIrq(1'b0, "R1 irq after reset");
    busRead(LoState, 32'h0, "R1 lo state");
    busRead(LoEn, 32'h0, "R1 lo enable");
    busRead(LoLvl, 32'h0, "R1 lo level");
    busRead(HiState, 32'h0, "R1 hi state");
    busRead(HiEn, 32'h0, "R1 hi enable");

    // R2 sticky edge on line 3, masked so no irq yet
    @(negedge clk) irqLines[3] = 1'b1;
    waitCyc(4);
    irqLines[3] = 1'b0;
    waitCyc(3);
    busRead(LoState, 32'h8, "R2 sticky edge bit3");
    checkIrq(1'b0, "R7 masked edge no irq");

    // R7 / R8 unmask the latched edge
    busWrite(LoEn, 32'h8);
    @(negedge clk);
    checkIrq(1'b0, "R8 irq one cycle after enable");
    @(negedge clk);
    checkIrq(1'b1, "R7 irq after unmask");
    busRead(LoLvl, 32'h0, "R6 level low");

    // R3 selective acknowledge
    busWrite(LoClr, 32'h10);
    busRead(LoState, 32'h8, "R3 unrelated clear keeps bit3");
    busWrite(LoClr, 32'h8);
    busRead(LoState, 32'h0, "R3 clear bit3");
    waitCyc(1);
    checkIrq(1'b0, "R3 irq drops after clear");

    // R3 multiple edges then clear-all
    @(negedge clk) begin irqLines[0] = 1'b1; irqLines[5] = 1'b1; irqLines[31] = 1'b1; end
    waitCyc(4);
    irqLines[0] = 1'b0; irqLines[5] = 1'b0; irqLines[31] = 1'b0;
    waitCyc(3);
    busRead(LoState, 32'h8000_0021, "R2 edges 0,5,31");
    checkIrq(1'b0, "R7 unmasked bits no irq");
    busWrite(LoClr, 32'hFFFF_FFFF);
    busRead(LoState, 32'h0, "R3 clear all");

    // R4 edge collides with acknowledge
    @(negedge clk) irqLines[7] = 1'b1;
    @(negedge clk);
    busWrite(LoClr, 32'h80);
    busRead(LoState, 32'h80, "R4 edge wins over clear");
    irqLines[7] = 1'b0;
    busWrite(LoClr, 32'h80);
    busRead(LoState, 32'h0, "R4 later clear works");

    // R5 / R6 level line 20
    @(negedge clk) irqLines[20] = 1'b1;
    waitCyc(4);
    busRead(LoState, 32'h0, "R5 level line not latched");
    busRead(LoLvl, 32'h0010_0000, "R6 level read while masked");
    checkIrq(1'b0, "R5 masked level no irq");
    busWrite(LoEn, 32'h0010_0008);
    waitCyc(2);
    checkIrq(1'b1, "R5 enabled level irq");
    irqLines[20] = 1'b0;
    waitCyc(4);
    checkIrq(1'b0, "R5 irq follows level low");
    busRead(LoLvl, 32'h0, "R6 level back low");

    // R9 read-only and write-ones behaviour
    @(negedge clk) irqLines[2] = 1'b1;
    waitCyc(4);
    irqLines[2] = 1'b0;
    waitCyc(3);
    busRead(LoClr, 32'h0, "R9 clear reads zero");
    busWrite(LoState, 32'h0);
    busWrite(LoLvl, 32'hFFFF_FFFF);
    busRead(LoState, 32'h4, "R9 state write ignored");
    busRead(LoLvl, 32'h0, "R9 level write ignored");
    busWrite(LoClr, 32'hFFFF_FFFF);

    // R11 misaligned write does not hit the enable word
    busWrite(6'h25, 32'h0);
    busRead(LoEn, 32'h0010_0008, "R11 misaligned write ignored");

    // R10 upper bank, bit 28 is edge-type there
    @(negedge clk) begin irqLines[40] = 1'b1; irqLines[60] = 1'b1; end
    waitCyc(4);
    irqLines[40] = 1'b0; irqLines[60] = 1'b0;
    waitCyc(3);
    busRead(HiState, 32'h1000_0100, "R10 hi edges latched");
    busRead(LoState, 32'h0, "R10 lo untouched");
    checkIrq(1'b0, "R10 hi masked no irq");
    busWrite(HiEn, 32'h100);
    waitCyc(2);
    checkIrq(1'b1, "R10 hi enabled irq");
    busRead(HiEn, 32'h100, "R10 hi enable readback");
    busRead(LoEn, 32'h0010_0008, "R10 lo enable unchanged");
    busWrite(HiClr, 32'hFFFF_FFFF);
    waitCyc(2);
    checkIrq(1'b0, "R10 hi cleared irq low");
    busWrite(LoEn, 32'h0);
    busRead(LoEn, 32'h0, "R7 disable all");

    waitCyc(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule